// File: doc/BRIEF.md
# Fixed Off-Time H-Bridge Chopper Controller

This block drives the four switch enables of one full-bridge winding driver and regulates winding current by peak-current chopping. A direction bit selects which diagonal pair of switches conducts. While that pair conducts, a digitized current-trip comparator is watched. When it fires, the bridge enters an off time of fixed length. During the off time the current decays in one of three ways, chosen by a mode select: slow, fast, or mixed. Mixed decay starts fast and turns slow after a programmable number of cycles. When the off time ends, the same pair is switched on again.

The comparator is ignored for a blanking interval each time the drive phase starts. The drive phase starts at the end of an off time, after a direction change, and when the bridge leaves the disabled state. A change of direction forces all four switches off for a dead time before the new pair conducts. A current-level code of zero disables the bridge, and so does an over-temperature flag. The level code is also passed on, one cycle later, to an external reference DAC.

The off time, blanking time and dead time are clock-cycle parameters. The length of the fast portion comes from an input port.

Top module: `hbridge_chopper`

## Requirements
- R1: In the drive phase, direction 1 turns on hs_a and ls_b and direction 0 turns on hs_b and ls_a. All other switches are off.
- R2: An accepted trip during drive starts an off time of exactly OFF_CYCLES cycles. The drive phase of the same direction follows it.
- R3: With decay_sel 00 or 11 (slow), both low-side switches are on and both high-side switches are off for the whole off time.
- R4: With decay_sel 01 (fast), all four switches are off for the whole off time.
- R5: With decay_sel 10 (mixed), all four switches are off for the first min(fast_len, OFF_CYCLES) cycles of the off time. After that, both low-side switches are on until the off time ends. A fast_len at or above OFF_CYCLES therefore gives fast decay for the whole off time.
- R6: For BLANK_CYCLES cycles after the drive phase is entered, trip has no effect and the drive pair stays on.
- R7: A change of dir while the bridge is enabled turns all switches off for DEAD_CYCLES cycles. The new pair then conducts and blanking applies. A further change during the dead time restarts it.
- R8: A level code of 000 turns all four switches off from the next cycle. A nonzero code, given while disabled, starts a blanked drive phase in the next cycle.
- R9: While overtemp is 1, all four switches are off from the next cycle. A blanked drive phase starts the cycle after the flag clears.
- R10: hs_a and ls_a are never 1 together, and hs_b and ls_b are never 1 together.
- R11: dac_code equals the level input registered by one clock.
- R12: During reset, all four switches are off and dac_code is 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir | input | 1 | Current direction: 1 selects hs_a/ls_b, 0 selects hs_b/ls_a |
| level | input | 3 | Current-level code; 000 disables the bridge |
| trip | input | 1 | Synchronized current-trip comparator output |
| decay_sel | input | 2 | Decay mode: 00 slow, 01 fast, 10 mixed, 11 slow |
| fast_len | input | FAST_W | Fast-decay cycles at the start of a mixed off time |
| overtemp | input | 1 | Over-temperature flag; forces all switches off |
| hs_a | output | 1 | High-side enable, leg A |
| ls_a | output | 1 | Low-side enable, leg A |
| hs_b | output | 1 | High-side enable, leg B |
| ls_b | output | 1 | Low-side enable, leg B |
| dac_code | output | 3 | Registered level code for the reference DAC |

## Verification
Two situations are hard to reach from the ports. The first is a trip that lands exactly on the last blanked cycle or on the first unblanked one. The second is a direction change that arrives while a dead time is already counting. The stimulus holds trip high, so that every drive phase chops right after its blanking window. It also sends trip pulses that fit entirely inside a blanking window, and it flips dir a few cycles into a dead time. A long pseudo-random phase mixes mode changes, fast_len values above and below the off time, level-zero cycles and over-temperature pulses. A behavioural model in the bench is compared with the outputs on every clock.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DEAD  = 2'd1,
    PH_DRIVE = 2'd2,
    PH_OFF   = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    DK_SLOW  = 2'b00,
    DK_FAST  = 2'b01,
    DK_MIXED = 2'b10,
    DK_SLOW2 = 2'b11
  } decay_t;

  typedef struct packed {
    logic hs_a;
    logic ls_a;
    logic hs_b;
    logic ls_b;
  } gates_t;

  localparam gates_t GATES_OFF = '0;

  // Largest of three counts, used to size the shared timer.
  function automatic logic [31:0] max3(input logic [31:0] a, input logic [31:0] b,
                                       input logic [31:0] c);
    logic [31:0] m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Fast portion of a mixed off time, never longer than the off time itself.
  function automatic logic [31:0] fast_span(input logic [31:0] req, input logic [31:0] off_len);
    return (req > off_len) ? off_len : req;
  endfunction

  // True while the off time should be in fast decay.
  function automatic logic fast_now(input decay_t m, input logic [31:0] elapsed,
                                    input logic [31:0] span);
    case (m)
      DK_FAST:  return 1'b1;
      DK_MIXED: return (elapsed < span);
      default:  return 1'b0;
    endcase
  endfunction

  function automatic gates_t drive_pair(input logic fwd);
    gates_t g;
    g = GATES_OFF;
    if (fwd) begin
      g.hs_a = 1'b1;
      g.ls_b = 1'b1;
    end else begin
      g.hs_b = 1'b1;
      g.ls_a = 1'b1;
    end
    return g;
  endfunction

  function automatic gates_t decay_pair(input logic fast);
    gates_t g;
    g = GATES_OFF;
    if (!fast) begin
      g.ls_a = 1'b1;
      g.ls_b = 1'b1;
    end
    return g;
  endfunction

endpackage

// File: rtl/hbc_seq.sv
module hbc_seq
  import hbc_pkg::*;
#(
  parameter int OFF_CYCLES   = 40,
  parameter int BLANK_CYCLES = 6,
  parameter int DEAD_CYCLES  = 50,
  parameter int CNT_W        = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir,
  input  logic             enable,
  input  logic             trip,
  output phase_t           phase,
  output logic             dir_lat,
  output logic [CNT_W-1:0] tmr
);

  localparam logic [CNT_W-1:0] BLANK_LD = CNT_W'(BLANK_CYCLES);
  localparam logic [CNT_W-1:0] DEAD_LD  = CNT_W'(DEAD_CYCLES);
  localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_CYCLES - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  phase_t           phase_n;
  logic             dir_n;
  logic [CNT_W-1:0] tmr_n;

  // Named internal events, shared by the next-state logic and the assertions.
  logic dir_flip;
  logic blanked;
  logic trip_hit;
  logic dead_done;
  logic off_done;

  assign dir_flip  = (phase != PH_IDLE) && (dir != dir_lat);
  assign blanked   = (phase == PH_DRIVE) && (tmr != '0);
  assign trip_hit  = (phase == PH_DRIVE) && (tmr == '0) && trip;
  assign dead_done = (phase == PH_DEAD) && (tmr == ONE);
  assign off_done  = (phase == PH_OFF) && (tmr == OFF_LAST);

  always_comb begin
    phase_n = phase;
    dir_n   = dir_lat;
    tmr_n   = tmr;
    if (!enable) begin
      phase_n = PH_IDLE;
      tmr_n   = '0;
      dir_n   = dir;
    end else if (phase == PH_IDLE) begin
      phase_n = PH_DRIVE;
      tmr_n   = BLANK_LD;
      dir_n   = dir;
    end else if (dir_flip) begin
      phase_n = PH_DEAD;
      tmr_n   = DEAD_LD;
      dir_n   = dir;
    end else begin
      case (phase)
        PH_DEAD: begin
          if (dead_done) begin
            phase_n = PH_DRIVE;
            tmr_n   = BLANK_LD;
          end else begin
            tmr_n = tmr - ONE;
          end
        end
        PH_DRIVE: begin
          if (blanked) begin
            tmr_n = tmr - ONE;
          end else if (trip_hit) begin
            phase_n = PH_OFF;
            tmr_n   = '0;
          end
        end
        PH_OFF: begin
          if (off_done) begin
            phase_n = PH_DRIVE;
            tmr_n   = BLANK_LD;
          end else begin
            tmr_n = tmr + ONE;
          end
        end
        default: begin
          phase_n = PH_IDLE;
          tmr_n   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      dir_lat <= 1'b0;
      tmr     <= '0;
    end else begin
      phase   <= phase_n;
      dir_lat <= dir_n;
      tmr     <= tmr_n;
    end
  end

  // R7: a direction change on an enabled bridge always enters the dead time.
  p_dead_on_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && dir_flip) |=> (phase == PH_DEAD));

  // R6: a blanked drive cycle stays in drive whatever trip does.
  p_blank_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && blanked && !dir_flip) |=> (phase == PH_DRIVE));

  // R2: the last off-time cycle returns to drive.
  p_off_returns_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && off_done && !dir_flip) |=> (phase == PH_DRIVE));

  // R2: an accepted trip always starts the off time from its first cycle.
  p_trip_starts_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && trip_hit && !dir_flip) |=> (phase == PH_OFF && tmr == '0));

endmodule

// File: rtl/hbc_gate_map.sv
module hbc_gate_map
  import hbc_pkg::*;
#(
  parameter int OFF_CYCLES = 40,
  parameter int CNT_W      = 6,
  parameter int FAST_W     = 6
) (
  input  phase_t            phase,
  input  logic              dir_lat,
  input  decay_t            mode,
  input  logic [CNT_W-1:0]  elapsed,
  input  logic [FAST_W-1:0] fast_len,
  output gates_t            gates
);

  logic [31:0] span;
  logic        fast_phase;

  assign span       = fast_span(32'(fast_len), 32'(OFF_CYCLES));
  assign fast_phase = fast_now(mode, 32'(elapsed), span);

  always_comb begin
    case (phase)
      PH_DRIVE: gates = drive_pair(dir_lat);
      PH_OFF:   gates = decay_pair(fast_phase);
      default:  gates = GATES_OFF;
    endcase
  end

endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
  import hbc_pkg::*;
#(
  parameter int OFF_CYCLES   = 40,
  parameter int BLANK_CYCLES = 6,
  parameter int DEAD_CYCLES  = 50,
  parameter int FAST_W       = $clog2(OFF_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir,
  input  logic [2:0]        level,
  input  logic              trip,
  input  logic [1:0]        decay_sel,
  input  logic [FAST_W-1:0] fast_len,
  input  logic              overtemp,
  output logic              hs_a,
  output logic              ls_a,
  output logic              hs_b,
  output logic              ls_b,
  output logic [2:0]        dac_code
);

  localparam int MAX_CNT = int'(max3(32'(OFF_CYCLES), 32'(BLANK_CYCLES), 32'(DEAD_CYCLES)));
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  phase_t           phase;
  logic             dir_lat;
  logic [CNT_W-1:0] tmr;
  logic             enable;
  gates_t           gates;

  assign enable = (level != 3'b000) && !overtemp;

  hbc_seq #(
    .OFF_CYCLES  (OFF_CYCLES),
    .BLANK_CYCLES(BLANK_CYCLES),
    .DEAD_CYCLES (DEAD_CYCLES),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .dir    (dir),
    .enable (enable),
    .trip   (trip),
    .phase  (phase),
    .dir_lat(dir_lat),
    .tmr    (tmr)
  );

  hbc_gate_map #(
    .OFF_CYCLES(OFF_CYCLES),
    .CNT_W     (CNT_W),
    .FAST_W    (FAST_W)
  ) u_map (
    .phase   (phase),
    .dir_lat (dir_lat),
    .mode    (decay_t'(decay_sel)),
    .elapsed (tmr),
    .fast_len(fast_len),
    .gates   (gates)
  );

  assign hs_a = gates.hs_a;
  assign ls_a = gates.ls_a;
  assign hs_b = gates.hs_b;
  assign ls_b = gates.ls_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dac_code <= 3'b000;
    else        dac_code <= level;
  end

  // R10: no leg ever conducts top and bottom together.
  p_leg_a_excl_r10: assert property (@(posedge clk) disable iff (!rst_n) !(hs_a && ls_a));
  p_leg_b_excl_r10: assert property (@(posedge clk) disable iff (!rst_n) !(hs_b && ls_b));

  // R11: the DAC code trails the level input by one clock.
  p_dac_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dac_code == $past(level)));

  // R8: a zero level code switches everything off in the next cycle.
  p_level_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 3'b000) |=> !(hs_a || ls_a || hs_b || ls_b));

  // R9: over-temperature switches everything off in the next cycle.
  p_shutdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp |=> !(hs_a || ls_a || hs_b || ls_b));

  // R3/R4/R5: no high-side switch is on during the off time.
  p_off_no_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OFF) |-> !(hs_a || hs_b));

endmodule

// File: tb/hbridge_chopper_bench.sv
module hbridge_chopper_bench;

  localparam int OFF   = 20;
  localparam int BLANK = 4;
  localparam int DEAD  = 8;
  localparam int FW    = $clog2(OFF + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dir = 1'b1;
  logic [2:0]    level = 3'b000;
  logic          trip = 1'b0;
  logic [1:0]    decay_sel = 2'b00;
  logic [FW-1:0] fast_len = '0;
  logic          overtemp = 1'b0;
  logic          hs_a, ls_a, hs_b, ls_b;
  logic [2:0]    dac_code;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #10 clk = ~clk;

  hbridge_chopper #(
    .OFF_CYCLES(OFF), .BLANK_CYCLES(BLANK), .DEAD_CYCLES(DEAD), .FAST_W(FW)
  ) u_hbridge_chopper (
    .clk(clk), .rst_n(rst_n), .dir(dir), .level(level), .trip(trip),
    .decay_sel(decay_sel), .fast_len(fast_len), .overtemp(overtemp),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b), .dac_code(dac_code)
  );

  // Behavioural reference: phase 0 disabled, 1 dead, 2 drive, 3 off time.
  int       m_ph = 0;
  int       m_left = 0;
  int       m_el = 0;
  bit       m_dir = 0;
  bit [2:0] m_dac = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_el = 0; m_dir = 0; m_dac = 0;
    end else begin
      m_dac = level;
      if (level == 0 || overtemp) begin
        m_ph = 0; m_dir = dir;
      end else if (m_ph == 0) begin
        m_ph = 2; m_left = BLANK; m_dir = dir;
      end else if (dir != m_dir) begin
        m_ph = 1; m_left = DEAD; m_dir = dir;
      end else if (m_ph == 1) begin
        m_left = m_left - 1;
        if (m_left == 0) begin m_ph = 2; m_left = BLANK; end
      end else if (m_ph == 2) begin
        if (m_left > 0) m_left = m_left - 1;
        else if (trip) begin m_ph = 3; m_el = 0; end
      end else begin
        m_el = m_el + 1;
        if (m_el == OFF) begin m_ph = 2; m_left = BLANK; end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected gates packed as {hs_a, ls_a, hs_b, ls_b}.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      begin
        logic [3:0] exp_g;
        string      tag;
        int         span;
        bit         fast;
        span = (int'(fast_len) > OFF) ? OFF : int'(fast_len);
        fast = (decay_sel == 2'b01) || (decay_sel == 2'b10 && m_el < span);
        exp_g = 4'b0000;
        if (!rst_n) tag = "R12";
        else if (m_ph == 0) tag = "R8/R9";
        else if (m_ph == 1) tag = "R7";
        else if (m_ph == 2) tag = (m_left > 0) ? "R6/R1" : "R1/R2";
        else if (decay_sel == 2'b01) tag = "R4";
        else if (decay_sel == 2'b10) tag = "R5";
        else tag = "R3/R2";
        if (m_ph == 2) exp_g = m_dir ? 4'b1001 : 4'b0110;
        if (m_ph == 3 && !fast) exp_g = 4'b0101;
        chk(tag, {hs_a, ls_a, hs_b, ls_b}, exp_g);
        chk("R10", 32'((hs_a && ls_a) || (hs_b && ls_b)), 32'd0);
        chk(rst_n ? "R11" : "R12", dac_code, m_dac);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] lfsr;
    cyc(4);
    rst_n = 1'b1;
    cyc(3);
    // R8: enable with a nonzero level, chop continuously in slow decay (R3).
    level = 3'd5; dir = 1'b1; trip = 1'b1; decay_sel = 2'b00;
    cyc(80);
    decay_sel = 2'b11; cyc(60);           // R3 alternate slow code
    decay_sel = 2'b01; cyc(60);           // R4 fast
    decay_sel = 2'b10; fast_len = 5'd7;  cyc(70);  // R5 mixed
    fast_len = 5'd31; cyc(60);            // R5 clamp above off time
    fast_len = 5'd0;  cyc(60);            // R5 zero fast portion
    fast_len = 5'd20; cyc(60);            // R5 exactly the off time
    // R6: trip pulses confined to the blanking window.
    trip = 1'b0; level = 3'd0; cyc(3);
    level = 3'd2; trip = 1'b1; cyc(BLANK); trip = 1'b0; cyc(10);
    trip = 1'b1; cyc(1); trip = 1'b0; cyc(30);
    // R7: direction changes, including one inside a dead time.
    dir = 1'b0; cyc(3); dir = 1'b1; cyc(3); dir = 1'b0; cyc(30);
    trip = 1'b1; cyc(40); dir = 1'b1; cyc(40);
    // R8: level zero during an off time, then re-enable.
    decay_sel = 2'b00; cyc(7); level = 3'd0; cyc(5); level = 3'd7; cyc(30);
    // R9: over-temperature during drive and release.
    overtemp = 1'b1; cyc(10); overtemp = 1'b0; cyc(30);
    overtemp = 1'b1; dir = 1'b0; cyc(2); overtemp = 1'b0; cyc(20);
    // Pseudo-random mix of all inputs.
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 4000; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      trip = lfsr[0];
      if (lfsr[13:8] == 6'd0) dir = ~dir;
      if (lfsr[20:14] == 7'd1) overtemp = ~overtemp;
      if (lfsr[27:21] == 7'd2) begin decay_sel = lfsr[29:28]; fast_len = lfsr[4:0]; end
      if (lfsr[7:3] == 5'd3) level = lfsr[31:29];
      if (lfsr[7:3] == 5'd4) level = 3'd0;
      cyc(1);
    end
    overtemp = 1'b0;
    cyc(5);
    report();
  end

endmodule